// File: doc/BRIEF.md
# Infrared Serial Pulse Encoder and Decoder

This block sits between a UART's serial bit stream and an optical infrared transceiver. On the transmit side it watches the UART's outgoing bit. Each zero bit becomes one short, active-high light pulse on the infrared output, and a one bit sends no light. On the receive side it turns light pulses (active low at the transceiver's receive pin) back into a UART-level bit stream. Each pulse becomes a zero that lasts one bit period.

Timing comes from a 16x baud tick. In low-power mode, the pulse length comes from a separate reference tick instead. When the infrared path is active, the wired serial output idles high and the wired receive and modem inputs are cut off. Two loopback routes are provided for test: infrared output to infrared input, and wired transmit to wired receive.

The encoder runs the state machine `TX_IDLE -> TX_NORM | TX_LOWP -> TX_IDLE`. The normal-mode pulse ends on its third baud tick, and the low-power pulse ends on its third reference tick. The decoder runs `RX_IDLE -> RX_ZERO`. It returns to `RX_IDLE` after sixteen baud ticks, and a fresh qualified pulse restarts `RX_ZERO`. Both machines fall back to their idle state whenever the infrared path is inactive.

Top module: `irda_endec`

## Requirements
- R1: In normal mode, a zero on `ser_tx_bit` makes `ir_tx` go high in the cycle after the 7th `tick16` of that bit. It stays high for exactly 3 `tick16` periods. A one bit produces no pulse.
- R2: With `ir_lowpwr` = 1, the pulse starts at the same point. It stays high until the 3rd `lp_tick` after its start, whatever the baud rate.
- R3: While the infrared path is inactive, `ir_tx` stays 0. Activity on `ir_rx` leaves no trace: on enabling, `ser_rx_bit` reads 1.
- R4: While the infrared path is active, the following hold:
  - `wire_tx` is held at 1.
  - `modem_gated` reads all zeros.
  - `ser_rx_bit` comes from the decoder, not from `wire_rx`.
- R5: The infrared path is active only when both `core_en` and `ir_en` are 1. With `core_en` = 0, `ir_en` has no effect: `wire_tx` follows `ser_tx_bit` and `modem_gated` follows `modem_raw`.
- R6: The decoder works on the synchronized receive path, where 0 means light. A low level seen at a `tick16` sample makes `ser_rx_bit` 0 for 16 ticks. A new pulse restarts that window, and a low shorter than a tick that covers no tick sample is ignored.
- R7: With `loop_en` = 1 and `loop_ir` = 1, the inverted `ir_tx` drives the decoder input and `ir_rx` is ignored.
- R8: With `loop_en` = 1 and `loop_ir` = 0, and the infrared path inactive, `ser_rx_bit` follows `ser_tx_bit`. With `loop_en` = 0, it follows `wire_rx`.
- R9: After reset, `ir_tx` is 0 and the decoder is idle, so `ser_rx_bit` is 1 once the path is enabled.
- R10: The bit-phase count restarts on every change of `ser_tx_bit`. A zero that follows a shortened one still pulses at its own 7th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle strobe at 16x the baud rate |
| lp_tick | input | 1 | One-cycle strobe of the low-power reference |
| core_en | input | 1 | Whole-UART enable |
| ir_en | input | 1 | Infrared path enable |
| ir_lowpwr | input | 1 | 1 = low-power pulse length |
| loop_en | input | 1 | Loopback enable |
| loop_ir | input | 1 | Loopback route select: 1 = infrared, 0 = wired |
| ser_tx_bit | input | 1 | Outgoing bit from the UART transmitter |
| wire_tx | output | 1 | Wired serial output |
| ser_rx_bit | output | 1 | Bit stream to the UART receiver |
| wire_rx | input | 1 | Wired serial input |
| ir_tx | output | 1 | Infrared output, active high |
| ir_rx | input | 1 | Infrared input, active low |
| modem_raw | input | MODEM_W | Modem status inputs |
| modem_gated | output | MODEM_W | Modem status passed to the UART |

## Verification
The bench uses the default parameters: 16 ticks per bit, pulse start at tick 7, 3-tick pulses and a 2-stage synchronizer. It drives `tick16` every 4 clocks and `lp_tick` every 5 clocks, so a bit lasts 64 cycles. At that rate a normal pulse is exactly 12 cycles wide, and a low-power pulse falls between 11 and 15 cycles depending on the reference phase. This makes the start offset, both pulse lengths, back-to-back zero windows, and a one-cycle glitch falling between tick samples all reachable within a few thousand cycles.

// File: rtl/irda_pkg.sv
package irda_pkg;

    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_NORM = 2'd1,
        TX_LOWP = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_ZERO = 1'b1
    } rx_state_e;

endpackage

// File: rtl/irda_sync.sv
module irda_sync #(
    parameter int   DEPTH     = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [DEPTH-1:0] stage;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage[i] <= RESET_VAL;
                end else begin
                    if (i == 0) stage[i] <= d;
                    else        stage[i] <= stage[(i > 0) ? i-1 : 0];
                end
            end
        end
    endgenerate

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/irda_tx_encoder.sv
module irda_tx_encoder
    import irda_pkg::*;
#(
    parameter int TICKS_PER_BIT  = 16,
    parameter int PULSE_START    = 7,
    parameter int PULSE_TICKS    = 3,
    parameter int LP_PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic lowpwr,
    input  logic tick16,
    input  logic lp_tick,
    input  logic bit_in,
    output logic pulse
);
    localparam int PHASE_W = $clog2(TICKS_PER_BIT);
    localparam int CNT_MAX = (PULSE_TICKS > LP_PULSE_TICKS) ? PULSE_TICKS : LP_PULSE_TICKS;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [PHASE_W-1:0] PHASE_LAST = PHASE_W'(TICKS_PER_BIT - 1);
    localparam logic [PHASE_W-1:0] START_PRE  = PHASE_W'(PULSE_START - 1);
    localparam logic [CNT_W-1:0]   NORM_LAST  = CNT_W'(PULSE_TICKS - 1);
    localparam logic [CNT_W-1:0]   LOWP_LAST  = CNT_W'(LP_PULSE_TICKS - 1);

    logic               prev_bit;
    logic               bit_edge;
    logic               start;
    logic [PHASE_W-1:0] phase;
    tx_state_e          state, nxt;
    logic [CNT_W-1:0]   cnt, cnt_nxt;

    assign bit_edge = bit_in ^ prev_bit;
    assign start    = active & tick16 & ~bit_edge & ~bit_in & (phase == START_PRE);

    // bit phase: restarts on each data change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_bit <= 1'b1;
            phase    <= '0;
        end else begin
            prev_bit <= bit_in;
            if (!active || bit_edge) phase <= '0;
            else if (tick16)         phase <= (phase == PHASE_LAST) ? '0 : phase + 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            TX_IDLE: if (start) begin
                nxt     = lowpwr ? TX_LOWP : TX_NORM;
                cnt_nxt = '0;
            end
            TX_NORM: if (tick16) begin
                if (cnt == NORM_LAST) nxt = TX_IDLE;
                cnt_nxt = cnt + 1'b1;
            end
            TX_LOWP: if (lp_tick) begin
                if (cnt == LOWP_LAST) nxt = TX_IDLE;
                cnt_nxt = cnt + 1'b1;
            end
            default: nxt = TX_IDLE;
        endcase
        if (!active) begin
            nxt     = TX_IDLE;
            cnt_nxt = '0;
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            TX_NORM, TX_LOWP: pulse = 1'b1;
            default:          pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/irda_rx_decoder.sv
module irda_rx_decoder
    import irda_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic tick16,
    input  logic light,
    output logic bit_out
);
    localparam int WIN_W = $clog2(TICKS_PER_BIT);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(TICKS_PER_BIT - 1);

    rx_state_e        state, nxt;
    logic [WIN_W-1:0] cnt;
    logic             pulse_seen;
    logic             qualify;

    assign qualify = active & tick16 & light & ~pulse_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_seen <= 1'b0;
        end else if (!active || !light) begin
            pulse_seen <= 1'b0;
        end else if (tick16) begin
            pulse_seen <= 1'b1;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
            cnt   <= '0;
        end else if (!active) begin
            state <= RX_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (qualify)                        cnt <= '0;
            else if (tick16 && state == RX_ZERO) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE: if (qualify) nxt = RX_ZERO;
            RX_ZERO: begin
                if (qualify)                        nxt = RX_ZERO;
                else if (tick16 && cnt == WIN_LAST) nxt = RX_IDLE;
            end
            default: nxt = RX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            RX_ZERO: bit_out = 1'b0;
            default: bit_out = 1'b1;
        endcase
    end
endmodule

// File: rtl/irda_endec.sv
module irda_endec
    import irda_pkg::*;
#(
    parameter int TICKS_PER_BIT  = 16,
    parameter int PULSE_START    = 7,
    parameter int PULSE_TICKS    = 3,
    parameter int LP_PULSE_TICKS = 3,
    parameter int SYNC_DEPTH     = 2,
    parameter int MODEM_W        = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick16,
    input  logic               lp_tick,
    input  logic               core_en,
    input  logic               ir_en,
    input  logic               ir_lowpwr,
    input  logic               loop_en,
    input  logic               loop_ir,
    input  logic               ser_tx_bit,
    output logic               wire_tx,
    output logic               ser_rx_bit,
    input  logic               wire_rx,
    output logic               ir_tx,
    input  logic               ir_rx,
    input  logic [MODEM_W-1:0] modem_raw,
    output logic [MODEM_W-1:0] modem_gated
);
    logic ir_active;
    logic tx_pulse;
    logic rx_raw;
    logic rx_sync;
    logic dec_bit;

    assign ir_active = core_en & ir_en;

    irda_tx_encoder #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .PULSE_START   (PULSE_START),
        .PULSE_TICKS   (PULSE_TICKS),
        .LP_PULSE_TICKS(LP_PULSE_TICKS)
    ) u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (ir_active),
        .lowpwr (ir_lowpwr),
        .tick16 (tick16),
        .lp_tick(lp_tick),
        .bit_in (ser_tx_bit),
        .pulse  (tx_pulse)
    );

    assign ir_tx  = tx_pulse & ir_active;
    assign rx_raw = (loop_en & loop_ir) ? ~ir_tx : ir_rx;

    irda_sync #(.DEPTH(SYNC_DEPTH), .RESET_VAL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (rx_raw),
        .q    (rx_sync)
    );

    irda_rx_decoder #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (ir_active),
        .tick16 (tick16),
        .light  (~rx_sync),
        .bit_out(dec_bit)
    );

    always_comb begin
        if (ir_active) begin
            wire_tx     = 1'b1;
            ser_rx_bit  = dec_bit;
            modem_gated = '0;
        end else begin
            wire_tx     = ser_tx_bit;
            ser_rx_bit  = (loop_en && !loop_ir) ? ser_tx_bit : wire_rx;
            modem_gated = modem_raw;
        end
    end
endmodule

// File: rtl/irda_endec_chk.sv
module irda_endec_chk #(
    parameter int TICKS_PER_BIT  = 16,
    parameter int PULSE_TICKS    = 3,
    parameter int LP_PULSE_TICKS = 3
) (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic lp_tick,
    input logic core_en,
    input logic ir_en,
    input logic ir_lowpwr,
    input logic ser_tx_bit,
    input logic ser_rx_bit,
    input logic ir_tx
);
    localparam int HW = 8;
    localparam logic [HW-1:0] HMAX = '1;

    logic          act;
    logic [HW-1:0] hi_ticks, hi_lp, lo_ticks;

    assign act = core_en & ir_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_ticks <= '0;
            hi_lp    <= '0;
        end else if (!ir_tx) begin
            hi_ticks <= '0;
            hi_lp    <= '0;
        end else begin
            if (tick16 && hi_ticks != HMAX) hi_ticks <= hi_ticks + 1'b1;
            if (lp_tick && hi_lp != HMAX)   hi_lp    <= hi_lp + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    lo_ticks <= '0;
        else if (!act || ser_rx_bit)   lo_ticks <= '0;
        else if (tick16 && lo_ticks != HMAX) lo_ticks <= lo_ticks + 1'b1;
    end

    // R1
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !ir_lowpwr && $fell(ir_tx)) |-> (hi_ticks == HW'(PULSE_TICKS)));

    // R1
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ir_tx) |-> ($past(tick16) && !$past(ser_tx_bit)));

    // R2
    lp_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && ir_lowpwr && $fell(ir_tx)) |-> (hi_lp == HW'(LP_PULSE_TICKS)));

    // R3
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> !ir_tx);

    // R6
    zero_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act) && $rose(ser_rx_bit)) |-> (lo_ticks >= HW'(TICKS_PER_BIT)));
endmodule

bind irda_endec irda_endec_chk #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .PULSE_TICKS   (PULSE_TICKS),
    .LP_PULSE_TICKS(LP_PULSE_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick16    (tick16),
    .lp_tick   (lp_tick),
    .core_en   (core_en),
    .ir_en     (ir_en),
    .ir_lowpwr (ir_lowpwr),
    .ser_tx_bit(ser_tx_bit),
    .ser_rx_bit(ser_rx_bit),
    .ir_tx     (ir_tx)
);

// File: tb/irda_endec_bench.sv
module irda_endec_bench;
    localparam int TP = 4;
    localparam int LQ = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0, lp_tick = 1'b0;
    logic       core_en = 1'b0, ir_en = 1'b0, ir_lowpwr = 1'b0;
    logic       loop_en = 1'b0, loop_ir = 1'b0;
    logic       ser_tx_bit = 1'b1, wire_rx = 1'b1, ir_rx = 1'b1;
    logic [3:0] modem_raw = 4'b1010;
    logic       wire_tx, ser_rx_bit, ir_tx;
    logic [3:0] modem_gated;

    int n_tests = 0, n_fail = 0;
    int cyc = 0, bit_start = 0;
    bit done = 1'b0;
    bit exp_lp_q[$];
    bit exp_bit_q[$];
    event samp_ev;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    irda_endec u_irda_endec (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .lp_tick(lp_tick),
        .core_en(core_en), .ir_en(ir_en), .ir_lowpwr(ir_lowpwr),
        .loop_en(loop_en), .loop_ir(loop_ir), .ser_tx_bit(ser_tx_bit),
        .wire_tx(wire_tx), .ser_rx_bit(ser_rx_bit), .wire_rx(wire_rx),
        .ir_tx(ir_tx), .ir_rx(ir_rx), .modem_raw(modem_raw),
        .modem_gated(modem_gated)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // driver: one UART bit of nt ticks on ser_tx_bit
    task automatic send_bit(input logic b, input int nt, input bit exp_pulse, input bit exp_rx);
        ser_tx_bit = b;
        bit_start  = cyc;
        if (exp_pulse && !b) exp_lp_q.push_back(ir_lowpwr);
        for (int k = 1; k <= nt; k++) begin
            repeat (TP-1) @(negedge clk);
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
            if (k == 15 && exp_rx) begin
                exp_bit_q.push_back(b);
                ->samp_ev;
            end
        end
    endtask

    // driver: one bit period of light on ir_rx (0 = light)
    task automatic send_ir_bit(input logic b, input bit glitch, input bit exp_rx);
        for (int k = 1; k <= 16; k++) begin
            if (glitch && k == 3) begin
                ir_rx = 1'b0;
                @(negedge clk);
                ir_rx = 1'b1;
                repeat (TP-2) @(negedge clk);
            end else begin
                repeat (TP-1) @(negedge clk);
            end
            tick16 = 1'b1;
            @(negedge clk);
            tick16 = 1'b0;
            if (k == 7 && !b) ir_rx = 1'b0;
            if (k == 10)      ir_rx = 1'b1;
            if (k == 15 && exp_rx) begin
                exp_bit_q.push_back(b);
                ->samp_ev;
            end
        end
    endtask

    // low-power reference tick
    initial begin
        forever begin
            repeat (LQ-1) @(negedge clk);
            lp_tick = 1'b1;
            @(negedge clk);
            lp_tick = 1'b0;
        end
    end

    // monitor: pulse start offset and width
    initial begin
        logic prev = 1'b0;
        int   w    = 0;
        forever begin
            @(negedge clk);
            if (ir_tx && !prev) begin
                w = 1;
                // R10 / R1: pulse starts at the 7th tick of its bit
                check((cyc - bit_start) == 7*TP, "R10 pulse start", cyc - bit_start, 7*TP);
            end else if (ir_tx) begin
                w++;
            end else if (prev) begin
                if (exp_lp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected pulse", w, 0);
                end else if (exp_lp_q.pop_front()) begin
                    check(w >= 2*LQ+1 && w <= 3*LQ, "R2 lowpower width", w, 3*LQ);
                end else begin
                    check(w == 3*TP, "R1 normal width", w, 3*TP);
                end
            end
            prev = ir_tx;
        end
    end

    // monitor: decoded bits
    initial begin
        forever begin
            @(samp_ev);
            if (exp_bit_q.size() != 0) begin
                bit e;
                e = exp_bit_q.pop_front();
                check(ser_rx_bit == e, "R6 decoded bit", ser_rx_bit, e);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            summary();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(ir_tx == 1'b0, "R9 ir_tx after reset", ir_tx, 0);
        check(wire_tx == 1'b1, "R9 wire_tx idle", wire_tx, 1);

        // R5: ir_en without core_en does nothing
        ir_en = 1'b1;
        ser_tx_bit = 1'b0;
        @(negedge clk);
        check(wire_tx == 1'b0, "R5 wire_tx follows", wire_tx, 0);
        check(modem_gated == 4'b1010, "R5 modem passes", modem_gated, 4'b1010);
        ser_tx_bit = 1'b1;
        @(negedge clk);
        send_bit(1'b0, 16, 1'b0, 1'b0);
        send_bit(1'b0, 16, 1'b0, 1'b0);
        send_bit(1'b1, 16, 1'b0, 1'b0);

        // R4 / R9: IR active
        wire_rx = 1'b0;
        core_en = 1'b1;
        @(negedge clk);
        check(ser_rx_bit == 1'b1, "R9 decoder idle", ser_rx_bit, 1);
        check(modem_gated == 4'b0000, "R4 modem gated", modem_gated, 0);
        ser_tx_bit = 1'b0;
        @(negedge clk);
        check(wire_tx == 1'b1, "R4 wire_tx marking", wire_tx, 1);
        ser_tx_bit = 1'b1;
        @(negedge clk);

        // R1: normal pulses
        send_bit(1'b0, 16, 1'b1, 1'b0);
        send_bit(1'b1, 16, 1'b1, 1'b0);
        send_bit(1'b0, 16, 1'b1, 1'b0);
        send_bit(1'b0, 16, 1'b1, 1'b0);
        send_bit(1'b1, 16, 1'b1, 1'b0);

        // R10: shortened one then zero
        send_bit(1'b1, 5, 1'b1, 1'b0);
        send_bit(1'b0, 16, 1'b1, 1'b0);
        send_bit(1'b1, 16, 1'b1, 1'b0);

        // R7: infrared loopback, external light ignored
        loop_en = 1'b1;
        loop_ir = 1'b1;
        ir_rx = 1'b0;
        @(negedge clk);
        send_bit(1'b0, 16, 1'b1, 1'b1);
        send_bit(1'b0, 16, 1'b1, 1'b1);
        send_bit(1'b1, 16, 1'b1, 1'b1);
        send_bit(1'b0, 16, 1'b1, 1'b1);
        send_bit(1'b1, 16, 1'b1, 1'b1);
        send_bit(1'b1, 16, 1'b1, 1'b1);

        // R2: low-power pulses through the loop
        ir_lowpwr = 1'b1;
        send_bit(1'b0, 16, 1'b1, 1'b1);
        send_bit(1'b1, 16, 1'b1, 1'b1);
        send_bit(1'b0, 16, 1'b1, 1'b1);
        send_bit(1'b1, 16, 1'b1, 1'b1);
        send_bit(1'b1, 16, 1'b1, 1'b1);
        ir_lowpwr = 1'b0;
        ir_rx = 1'b1;
        @(negedge clk);
        loop_en = 1'b0;
        loop_ir = 1'b0;
        @(negedge clk);

        // R6: external receive, back-to-back zeros and a glitch
        send_ir_bit(1'b0, 1'b0, 1'b1);
        send_ir_bit(1'b0, 1'b0, 1'b1);
        send_ir_bit(1'b1, 1'b0, 1'b1);
        send_ir_bit(1'b0, 1'b0, 1'b1);
        send_ir_bit(1'b1, 1'b0, 1'b1);
        send_ir_bit(1'b1, 1'b1, 1'b1);
        send_ir_bit(1'b1, 1'b0, 1'b1);

        // R3: path off, light and zeros ignored
        ir_en = 1'b0;
        @(negedge clk);
        check(ser_rx_bit == 1'b0, "R3 wire_rx followed", ser_rx_bit, 0);
        send_bit(1'b0, 16, 1'b0, 1'b0);
        send_ir_bit(1'b0, 1'b0, 1'b0);
        ir_rx = 1'b0;
        repeat (3) @(negedge clk);
        ir_rx = 1'b1;
        send_bit(1'b1, 16, 1'b0, 1'b0);
        ir_en = 1'b1;
        @(negedge clk);
        check(ser_rx_bit == 1'b1, "R3 no trace after enable", ser_rx_bit, 1);
        check(ir_tx == 1'b0, "R3 ir_tx quiet", ir_tx, 0);

        // R8: wired loopback
        ir_en = 1'b0;
        loop_en = 1'b1;
        ser_tx_bit = 1'b1;
        @(negedge clk);
        check(ser_rx_bit == 1'b1, "R8 loop high", ser_rx_bit, 1);
        ser_tx_bit = 1'b0;
        @(negedge clk);
        check(ser_rx_bit == 1'b0, "R8 loop low", ser_rx_bit, 0);
        loop_en = 1'b0;
        ser_tx_bit = 1'b1;
        @(negedge clk);
        check(ser_rx_bit == 1'b0, "R8 no loop follows wire_rx", ser_rx_bit, 0);

        repeat (4) @(negedge clk);
        check(exp_lp_q.size() == 0, "R1 missing pulses", exp_lp_q.size(), 0);
        done = 1'b1;
        summary();
    end
endmodule